// File: doc/BRIEF.md
# Single-Precision Float Compare Unit

This unit compares two 32-bit single-precision floating-point operands for a processor's floating-point pipeline. A 3-bit predicate code picks one of seven tests: unordered, less-than, equal, less-or-equal, greater-than, not-equal and greater-or-equal. The 1-bit answer is returned zero-extended to a 32-bit word, so it can be written straight into a general register.

Each operand is classified as zero, ordinary number, quiet NaN or signaling NaN. The equal, not-equal and unordered tests are quiet and flag only signaling NaNs. The four ordering tests are signaling and flag any NaN. A flag sets a sticky invalid-operation bit, which stays set until a software clear strobe. When a test flags, an exception request with a fixed cause code is raised only if a configuration enable and a run-time enable are both set.

A two-state controller sequences the block. In `ST_IDLE` nothing is reported. A valid strobe (transition IDLE->REPORT) registers the answer, and `ST_REPORT` presents it for one cycle. Another strobe in REPORT keeps the controller in REPORT (REPORT->REPORT). No strobe returns it to IDLE (REPORT->IDLE).

Top module: `fcmp_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, `out_valid`, `result`, `fsr_invalid`, `exc_req` and `exc_cause` are all zero.
- R2: A strobe on `in_valid` at a clock edge gives `out_valid` high for the cycle after that edge, with the answer on `result`. `out_valid` is low in any cycle that does not follow a strobe, and `result[31:1]` is always zero.
- R3: Predicate codes are: 0 unordered, 1 lt, 2 eq, 3 le, 4 gt, 5 ne, 6 ge, 7 reserved. Unordered returns 1 when either operand is a NaN.
- R4: eq returns 1 for equal non-NaN operands and 0 if any operand is a NaN. ne always returns the inverse of eq.
- R5: lt returns 1 when `op_b` is less than `op_a`, so the operands are taken in swapped order.
- R6: gt returns 1 when `op_a` is less than `op_b`. ge returns the inverse of that, so ge returns 1 whenever either operand is a NaN.
- R7: le returns 1 when `op_a` is less than or equal to `op_b`, with both operands non-NaN.
- R8: +0 and -0 compare equal. Other non-NaN values are ordered by sign and then by magnitude, with infinities at the extremes.
- R9: A NaN has exponent field bits 30:23 all ones and a nonzero fraction in bits 22:0. Fraction bit 22 set marks it quiet, and bit 22 clear marks it signaling.
- R10: A test flags invalid as follows. Codes 1, 3, 4 and 6 flag on any NaN operand. Codes 0, 2 and 5 flag only on a signaling NaN. Code 7 returns 0 and never flags.
- R11: `fsr_invalid` is set at the edge of a flagging strobe and stays set. It clears only through `fsr_clr`. When a flag and `fsr_clr` arrive at the same edge, the set wins.
- R12: `exc_req` is high together with `out_valid` exactly when that operation flagged while `cfg_exc_en` and `run_exc_en` were both high at the strobe. `exc_cause` is then 6, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| pred | input | 3 | Predicate code |
| cfg_exc_en | input | 1 | Configuration-level FPU exception enable |
| run_exc_en | input | 1 | Run-time exception enable |
| fsr_clr | input | 1 | Software clear of the invalid status bit |
| out_valid | output | 1 | Result valid, one cycle per strobe |
| result | output | 32 | Zero-extended compare answer |
| fsr_invalid | output | 1 | Sticky invalid-operation status |
| exc_req | output | 1 | FPU exception request |
| exc_cause | output | 5 | Exception cause code |

## Verification
A misclassified operand, for example a quiet NaN taken as signaling, shows up on `fsr_invalid` and `exc_req` one cycle after the strobe that carried it. The inverted predicates ne and ge expose it directly in `result`. A wrong controller state appears at once as an `out_valid` that is missing or repeated. A lost sticky bit can stay hidden for many cycles, until a later non-flagging operation finds `fsr_invalid` low, so the bench checks the status after every operation.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = WORD_W - 1;

    typedef enum logic [2:0] {
        PR_UNORD = 3'd0,
        PR_LT    = 3'd1,
        PR_EQ    = 3'd2,
        PR_LE    = 3'd3,
        PR_GT    = 3'd4,
        PR_NE    = 3'd5,
        PR_GE    = 3'd6,
        PR_RSVD  = 3'd7
    } pred_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } fsm_e;

    typedef struct packed {
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
        logic             sign;
        logic [MAG_W-1:0] mag;
    } opclass_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opclass_t          cls
);
    localparam int QBIT = FRAC_W - 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;

    always_comb begin
        exp_f       = word[WORD_W-2 -: EXP_W];
        frac_f      = word[FRAC_W-1:0];
        exp_max     = &exp_f;
        cls.sign    = word[WORD_W-1];
        cls.mag     = word[MAG_W-1:0];
        cls.is_nan  = exp_max && (|frac_f);
        cls.is_snan = cls.is_nan && !frac_f[QBIT];
        cls.is_zero = ~|word[MAG_W-1:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  opclass_t x,
    input  opclass_t y,
    output logic     x_lt_y,
    output logic     x_eq_y
);
    logic both_zero;

    always_comb begin
        both_zero = x.is_zero && y.is_zero;
        x_eq_y    = both_zero || ({x.sign, x.mag} == {y.sign, y.mag});
        if (both_zero)
            x_lt_y = 1'b0;
        else if (x.sign != y.sign)
            x_lt_y = x.sign;
        else if (x.sign)
            x_lt_y = x.mag > y.mag;
        else
            x_lt_y = x.mag < y.mag;
    end
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
    import fcmp_pkg::*;
(
    input  pred_e    pred,
    input  opclass_t ca,
    input  opclass_t cb,
    input  logic     a_lt_b,
    input  logic     b_lt_a,
    input  logic     a_eq_b,
    output logic     res,
    output logic     inv
);
    logic any_nan, any_snan, ordered, eq_q;

    always_comb begin
        any_nan  = ca.is_nan || cb.is_nan;
        any_snan = ca.is_snan || cb.is_snan;
        ordered  = !any_nan;
        eq_q     = ordered && a_eq_b;
        res      = 1'b0;
        inv      = 1'b0;
        unique case (pred)
            PR_UNORD: begin res = any_nan;               inv = any_snan; end
            PR_LT:    begin res = ordered && b_lt_a;     inv = any_nan;  end
            PR_EQ:    begin res = eq_q;                  inv = any_snan; end
            PR_LE:    begin res = ordered && (a_lt_b || a_eq_b); inv = any_nan; end
            PR_GT:    begin res = ordered && a_lt_b;     inv = any_nan;  end
            PR_NE:    begin res = !eq_q;                 inv = any_snan; end
            PR_GE:    begin res = !(ordered && a_lt_b);  inv = any_nan;  end
            PR_RSVD:  begin res = 1'b0;                  inv = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int                 CAUSE_W   = 5,
    parameter logic [CAUSE_W-1:0] FPU_CAUSE = 'd6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        op_a,
    input  logic [31:0]        op_b,
    input  logic [2:0]         pred,
    input  logic               cfg_exc_en,
    input  logic               run_exc_en,
    input  logic               fsr_clr,
    output logic               out_valid,
    output logic [31:0]        result,
    output logic               fsr_invalid,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause
);
    opclass_t cls [2];
    logic     lt_v [2];
    logic     eq_v [2];
    logic     res_c, inv_c;
    fsm_e     state, state_nx;

    logic     res_q, exc_q, fsr_q;
    logic [CAUSE_W-1:0] cause_q;

    fcmp_classify u_cls_a (.word(op_a), .cls(cls[0]));
    fcmp_classify u_cls_b (.word(op_b), .cls(cls[1]));

    for (genvar g = 0; g < 2; g++) begin : g_order
        fcmp_order u_ord (
            .x      (cls[g]),
            .y      (cls[1-g]),
            .x_lt_y (lt_v[g]),
            .x_eq_y (eq_v[g])
        );
    end

    fcmp_predicate u_pred (
        .pred   (pred_e'(pred)),
        .ca     (cls[0]),
        .cb     (cls[1]),
        .a_lt_b (lt_v[0]),
        .b_lt_a (lt_v[1]),
        .a_eq_b (eq_v[0]),
        .res    (res_c),
        .inv    (inv_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_nx = in_valid ? ST_REPORT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= 1'b0;
            exc_q   <= 1'b0;
            cause_q <= '0;
            fsr_q   <= 1'b0;
        end else begin
            exc_q   <= 1'b0;
            cause_q <= '0;
            if (in_valid) begin
                res_q <= res_c;
                if (inv_c && cfg_exc_en && run_exc_en) begin
                    exc_q   <= 1'b1;
                    cause_q <= FPU_CAUSE;
                end
            end
            if (in_valid && inv_c) fsr_q <= 1'b1;
            else if (fsr_clr)      fsr_q <= 1'b0;
        end
    end

    always_comb begin
        out_valid   = (state == ST_REPORT);
        result      = {31'd0, res_q};
        fsr_invalid = fsr_q;
        exc_req     = exc_q;
        exc_cause   = cause_q;
    end
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
    parameter int CAUSE_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               cfg_exc_en,
    input logic               run_exc_en,
    input logic               fsr_clr,
    input logic               out_valid,
    input logic [31:0]        result,
    input logic               fsr_invalid,
    input logic               exc_req,
    input logic [CAUSE_W-1:0] exc_cause
);
    assert_strobe_reports_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        result[31:1] == 31'd0);
    assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fsr_invalid && !fsr_clr) |=> fsr_invalid);
    assert_set_only_by_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsr_invalid && !in_valid) |=> !fsr_invalid);
    assert_exc_with_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (out_valid && fsr_invalid));
    assert_exc_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_exc_en && run_exc_en) |=> !exc_req);
    assert_cause_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (exc_cause == '0));
endmodule

bind fcmp_unit fcmp_unit_chk #(.CAUSE_W(CAUSE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .cfg_exc_en  (cfg_exc_en),
    .run_exc_en  (run_exc_en),
    .fsr_clr     (fsr_clr),
    .out_valid   (out_valid),
    .result      (result),
    .fsr_invalid (fsr_invalid),
    .exc_req     (exc_req),
    .exc_cause   (exc_cause)
);

// File: tb/tb_fcmp_unit.sv
module tb_fcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, cfg_exc_en, run_exc_en, fsr_clr;
    logic [31:0] op_a, op_b;
    logic [2:0]  pred;
    logic        out_valid, fsr_invalid, exc_req;
    logic [31:0] result;
    logic [4:0]  exc_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit fsr_m = 0;

    always #5 clk = ~clk;

    fcmp_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .pred(pred), .cfg_exc_en(cfg_exc_en), .run_exc_en(run_exc_en),
        .fsr_clr(fsr_clr), .out_valid(out_valid), .result(result),
        .fsr_invalid(fsr_invalid), .exc_req(exc_req), .exc_cause(exc_cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction
    function automatic longint key(input logic [31:0] x);
        longint m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [2:0] p, output bit res, output bit inv);
        bit nan  = is_nan(a) || is_nan(b);
        bit snan = is_snan(a) || is_snan(b);
        longint ka = key(a);
        longint kb = key(b);
        case (p)
            3'd0: begin res = nan;                  inv = snan; end
            3'd1: begin res = !nan && (kb < ka);    inv = nan;  end
            3'd2: begin res = !nan && (ka == kb);   inv = snan; end
            3'd3: begin res = !nan && (ka <= kb);   inv = nan;  end
            3'd4: begin res = !nan && (ka < kb);    inv = nan;  end
            3'd5: begin res = nan || (ka != kb);    inv = snan; end
            3'd6: begin res = nan || (ka >= kb);    inv = nan;  end
            default: begin res = 0;                 inv = 0;    end
        endcase
    endfunction

    function automatic string ptag(input logic [2:0] p);
        case (p)
            3'd0: return "R3 unordered";
            3'd1: return "R5 lt";
            3'd2: return "R4 eq";
            3'd3: return "R7 le";
            3'd4: return "R6 gt";
            3'd5: return "R4 ne";
            3'd6: return "R6 ge";
            default: return "R10 reserved";
        endcase
    endfunction

    // called at a negedge; returns at the next negedge with outputs checked
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [2:0] p,
                          input bit cfg, input bit run, input bit clr);
        bit r, iv, exp_fsr, exp_exc;
        model(a, b, p, r, iv);
        exp_fsr = iv ? 1'b1 : (clr ? 1'b0 : fsr_m);
        exp_exc = iv && cfg && run;
        op_a = a; op_b = b; pred = p; cfg_exc_en = cfg; run_exc_en = run;
        fsr_clr = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; fsr_clr = 1'b0;
        chk({ptag(p), " result"}, result, {31'd0, r});
        chk("R2 out_valid", {31'd0, out_valid}, 32'd1);
        chk("R10 R11 fsr_invalid", {31'd0, fsr_invalid}, {31'd0, exp_fsr});
        chk("R12 exc_req", {31'd0, exc_req}, {31'd0, exp_exc});
        chk("R12 exc_cause", {27'd0, exc_cause}, exp_exc ? 32'd6 : 32'd0);
        fsr_m = exp_fsr;
    endtask

    function automatic logic [31:0] pick(input int sel, input logic [31:0] other);
        logic [31:0] rv = $urandom;
        case (sel)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000;
            3: return 32'hFF80_0000;
            4: return {rv[31], 8'hFF, 1'b1, rv[21:0]};
            5: return {rv[31], 8'hFF, 1'b0, rv[21:1], 1'b1};
            6: return other;
            7: return {other[31:1], ~other[0]};
            default: return rv;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; in_valid = 0; op_a = 0; op_b = 0; pred = 0;
        cfg_exc_en = 0; run_exc_en = 0; fsr_clr = 0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {31'd0, out_valid}, 0);
        chk("R1 result", result, 0);
        chk("R1 fsr_invalid", {31'd0, fsr_invalid}, 0);
        chk("R1 exc", {26'd0, exc_req, exc_cause}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R2 idle no valid", {31'd0, out_valid}, 0);

        // directed
        run_op(32'h3F80_0000, 32'h4000_0000, 3'd1, 0, 0, 0); // R5 lt: 2<1 false
        run_op(32'h4000_0000, 32'h3F80_0000, 3'd1, 0, 0, 0); // R5 lt: 1<2 true
        run_op(32'h3F80_0000, 32'h4000_0000, 3'd4, 0, 0, 0); // R6 gt
        run_op(32'h0000_0000, 32'h8000_0000, 3'd2, 0, 0, 0); // R8 +0 == -0
        run_op(32'h8000_0000, 32'h0000_0000, 3'd3, 0, 0, 0); // R8 R7 le
        run_op(32'hBF80_0000, 32'hC000_0000, 3'd4, 0, 0, 0); // R8 negatives
        run_op(32'hFF80_0000, 32'h7F80_0000, 3'd4, 0, 0, 0); // R8 infinities
        run_op(32'h7FC0_0000, 32'h3F80_0000, 3'd2, 1, 1, 0); // R9 qNaN eq quiet
        run_op(32'h7FC0_0000, 32'h3F80_0000, 3'd0, 1, 1, 0); // R3 unordered qNaN
        run_op(32'h7FC0_0000, 32'h3F80_0000, 3'd6, 0, 1, 0); // R6 ge NaN=1, R10 flag, cfg off
        run_op(32'h3F80_0000, 32'h3F80_0000, 3'd2, 1, 1, 1); // R11 clear
        run_op(32'h3F80_0000, 32'h7F80_0001, 3'd5, 1, 1, 0); // R9 sNaN ne flags, R12 exc
        run_op(32'h3F80_0000, 32'h7F80_0001, 3'd7, 1, 1, 1); // R10 reserved, clear
        run_op(32'h7F80_0001, 32'h0, 3'd0, 1, 0, 1);         // R11 set wins over clear
        // R11 clear-only strobe
        fsr_clr = 1; @(negedge clk); fsr_clr = 0; fsr_m = 0;
        chk("R11 clear strobe", {31'd0, fsr_invalid}, 0);
        chk("R2 no strobe", {31'd0, out_valid}, 0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            a = pick($urandom_range(0, 10), 32'h3F80_0000);
            b = pick($urandom_range(0, 10), a);
            run_op(a, b, 3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
                   ($urandom_range(0, 7) == 0));
            if (($urandom_range(0, 3)) == 0) begin
                @(negedge clk);
                chk("R2 gap", {31'd0, out_valid}, 0);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule